// File: doc/BRIEF.md
# Radio Power-State and Oscillator Controller

This block manages the power states of a small radio core that is attached over SPI. It has three states: active idle, oscillator-off and deep sleep. From those states it drives the enable for the crystal oscillator and the enable for the voltage regulator of the digital core. The SPI shifter upstream turns received commands into one-cycle strobes: a software reset, an oscillator-off request and a power-down request. A power request is accepted only in idle, and it waits until the host releases chip select. When the host pulls chip select low again, the oscillator and the regulator come back on. The controller then returns to idle.

While chip select is low, the block drives a readiness level onto the serial data-out line. The level is high while the oscillator is not yet stable and low once it is stable. While chip select is high the line is released, which is shown by a separate output-enable. A configuration bit can keep the oscillator running in every state. A sticky flag records power strobes that arrived when they could not be honoured.

Top module: `radio_pwr_ctrl`

## Requirements
- R1: While `por_n` is low, and after it rises, the controller is in idle with the following outputs: `state_o` = 0, `osc_en_o` = 1, `reg_en_o` = 1 and `strobe_err_o` = 0. In this reset state `so_level_o` is 1, meaning not ready.
- R2: The stability flag is registered. `so_level_o` goes to 0 one cycle after `xosc_stable_i` is seen high while the oscillator is enabled. It returns to 1 one cycle after the stable input or the oscillator enable goes low.
- R3: The state encoding is idle = 0, oscillator-off = 1 and sleep = 2. An oscillator-off strobe (`strobe_i[1]`) or a power-down strobe (`strobe_i[2]`) received in idle with no request pending is held as a pending request. The state does not change while `cs_n_i` is low. The first clock edge at which `cs_n_i` is high moves the state to 1 or 2 respectively.
- R4: In state 1 or 2, a clock edge with `cs_n_i` low returns the controller to idle.
- R5: A reset strobe (`strobe_i[0]`) in any state returns the controller to idle at the next edge. It also clears any pending request and the error flag.
- R6: `osc_en_o` is 1 in idle or whenever `force_osc_on_i` is 1, sleep included. Otherwise it is 0.
- R7: `reg_en_o` is 0 only in sleep.
- R8: `so_oe_o` equals the inverse of `cs_n_i`, so the data-out line is driven only while chip select is low.
- R9: An oscillator-off or power-down strobe is ignored in the following cases: outside idle, or in idle while a request is already pending. Such a strobe has no effect on the state and sets `strobe_err_o`, which stays set until a reset strobe or power-on reset.
- R10: `xosc_stable_i` has no effect while `osc_en_o` is 0. After a wake-up, `so_level_o` stays 1 for at least one cycle, even if the stable input was held high throughout.
- R11: When several strobe bits are set in one cycle, priority goes reset first, then oscillator-off, then power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| cs_n_i | input | 1 | SPI chip select, active low |
| strobe_i | input | 3 | Decoded command strobes: [0] reset, [1] oscillator off, [2] power down |
| xosc_stable_i | input | 1 | Oscillator stable indication |
| force_osc_on_i | input | 1 | Keep the oscillator enabled in every state |
| state_o | output | 2 | Power state: 0 idle, 1 oscillator off, 2 sleep |
| osc_en_o | output | 1 | Crystal oscillator enable |
| reg_en_o | output | 1 | Digital-core regulator enable |
| so_level_o | output | 1 | Level for data out: 1 not ready, 0 ready |
| so_oe_o | output | 1 | Output enable for data out |
| strobe_err_o | output | 1 | Sticky flag for ignored power strobes |

## Verification
The bench issues power strobes while chip select is held low. It checks that the state stays at idle until release. A design that acted on the strobe at once would shut the oscillator down in the middle of an SPI transfer. The bench holds the stable input high through an oscillator-off period. A design that ignored the enable would report ready straight after wake-up, before the oscillator could be running. The bench also sends strobes outside idle, sends strobes on top of a pending request, and sets several strobe bits in one cycle. These cases catch a design that re-targets a request, forgets to flag the error, or ranks the commands in the wrong order.

// File: rtl/radio_pwr_pkg.sv
package radio_pwr_pkg;
    localparam int STB_W    = 3;
    localparam int STB_RST  = 0;
    localparam int STB_XOFF = 1;
    localparam int STB_PWD  = 2;
    localparam int ST_W     = 2;

    typedef enum logic [ST_W-1:0] {
        PS_IDLE  = 2'd0,
        PS_XOFF  = 2'd1,
        PS_SLEEP = 2'd2
    } pstate_e;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_RESET,
        CMD_XOFF,
        CMD_PWD
    } cmd_e;

    typedef struct packed {
        pstate_e state;
        pstate_e pend;   // PS_IDLE means nothing pending
        logic    err;
    } ctl_s;
endpackage

// File: rtl/radio_strobe_dec.sv
module radio_strobe_dec
    import radio_pwr_pkg::*;
(
    input  logic [STB_W-1:0] strobe_i,
    output cmd_e             cmd_o
);
    always_comb begin
        if (strobe_i[STB_RST])       cmd_o = CMD_RESET;
        else if (strobe_i[STB_XOFF]) cmd_o = CMD_XOFF;
        else if (strobe_i[STB_PWD])  cmd_o = CMD_PWD;
        else                         cmd_o = CMD_NONE;
    end
endmodule

// File: rtl/radio_ready.sv
module radio_ready (
    input  logic clk,
    input  logic por_n,
    input  logic osc_en_i,
    input  logic xosc_stable_i,
    input  logic cs_n_i,
    output logic so_level_o,
    output logic so_oe_o
);
    logic stable_d, stable_q;

    always_comb begin
        stable_d = osc_en_i & xosc_stable_i;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) stable_q <= 1'b0;
        else        stable_q <= stable_d;
    end

    assign so_level_o = ~stable_q;
    assign so_oe_o    = ~cs_n_i;

    // R10: with the oscillator off, the next cycle shows not ready
    a_r10_gated_stable: assert property (@(posedge clk) disable iff (!por_n)
        !osc_en_i |=> so_level_o);

    // R2: stable seen with oscillator on gives ready one cycle later
    a_r2_ready_follows: assert property (@(posedge clk) disable iff (!por_n)
        (osc_en_i && xosc_stable_i) |=> !so_level_o);
endmodule

// File: rtl/radio_pwr_ctrl.sv
module radio_pwr_ctrl
    import radio_pwr_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             cs_n_i,
    input  logic [STB_W-1:0] strobe_i,
    input  logic             xosc_stable_i,
    input  logic             force_osc_on_i,
    output logic [ST_W-1:0]  state_o,
    output logic             osc_en_o,
    output logic             reg_en_o,
    output logic             so_level_o,
    output logic             so_oe_o,
    output logic             strobe_err_o
);
    localparam ctl_s CTL_RST = '{state: PS_IDLE, pend: PS_IDLE, err: 1'b0};

    cmd_e cmd;
    ctl_s ctl_d, ctl_q;
    logic pwr_cmd;

    radio_strobe_dec u_dec (
        .strobe_i (strobe_i),
        .cmd_o    (cmd)
    );

    assign pwr_cmd = (cmd == CMD_XOFF) || (cmd == CMD_PWD);

    always_comb begin
        ctl_d = ctl_q;
        if (cmd == CMD_RESET) begin
            ctl_d = CTL_RST;
        end else if (ctl_q.state != PS_IDLE) begin
            if (pwr_cmd) ctl_d.err = 1'b1;
            if (!cs_n_i) ctl_d.state = PS_IDLE;
        end else if (ctl_q.pend != PS_IDLE) begin
            if (pwr_cmd) ctl_d.err = 1'b1;
            if (cs_n_i) begin
                ctl_d.state = ctl_q.pend;
                ctl_d.pend  = PS_IDLE;
            end
        end else begin
            if (cmd == CMD_XOFF)     ctl_d.pend = PS_XOFF;
            else if (cmd == CMD_PWD) ctl_d.pend = PS_SLEEP;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign state_o      = ctl_q.state;
    assign osc_en_o     = force_osc_on_i | (ctl_q.state == PS_IDLE);
    assign reg_en_o     = (ctl_q.state != PS_SLEEP);
    assign strobe_err_o = ctl_q.err;

    radio_ready u_ready (
        .clk           (clk),
        .por_n         (por_n),
        .osc_en_i      (osc_en_o),
        .xosc_stable_i (xosc_stable_i),
        .cs_n_i        (cs_n_i),
        .so_level_o    (so_level_o),
        .so_oe_o       (so_oe_o)
    );

    // R3: leaving idle for a low-power state requires chip select released
    a_r3_leave_on_release: assert property (@(posedge clk) disable iff (!por_n)
        ($past(state_o) == PS_IDLE && state_o != PS_IDLE) |-> $past(cs_n_i));

    // R4: chip select low in a low-power state wakes to idle
    a_r4_wake: assert property (@(posedge clk) disable iff (!por_n)
        (state_o != PS_IDLE && !cs_n_i) |=> state_o == PS_IDLE);

    // R5: reset strobe returns to idle with the flag cleared
    a_r5_soft_reset: assert property (@(posedge clk) disable iff (!por_n)
        strobe_i[STB_RST] |=> (state_o == PS_IDLE && !strobe_err_o));

    // R7: the regulator drops only on entry to sleep after release
    a_r7_reg_drop: assert property (@(posedge clk) disable iff (!por_n)
        $fell(reg_en_o) |-> ($past(cs_n_i) && state_o == PS_SLEEP));

    // R9: a power strobe outside idle raises the sticky flag
    a_r9_flag: assert property (@(posedge clk) disable iff (!por_n)
        (state_o != PS_IDLE && !strobe_i[STB_RST] && (strobe_i[STB_XOFF] || strobe_i[STB_PWD]))
        |=> strobe_err_o);

    // R6: forced oscillator stays on regardless of state
    a_r6_forced: assert property (@(posedge clk) disable iff (!por_n)
        force_osc_on_i |-> osc_en_o);
endmodule

// File: tb/radio_pwr_ctrl_bench.sv
`timescale 1ns/1ps
module radio_pwr_ctrl_bench;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       cs_n = 1'b1;
    logic [2:0] strobe = 3'b000;
    logic       xs = 1'b0;
    logic       force_on = 1'b0;
    logic [1:0] state;
    logic       osc_en, reg_en, so_level, so_oe, serr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    radio_pwr_ctrl u_radio_pwr_ctrl (
        .clk(clk), .por_n(por_n), .cs_n_i(cs_n), .strobe_i(strobe),
        .xosc_stable_i(xs), .force_osc_on_i(force_on),
        .state_o(state), .osc_en_o(osc_en), .reg_en_o(reg_en),
        .so_level_o(so_level), .so_oe_o(so_oe), .strobe_err_o(serr)
    );

    // behavioural reference model
    int m_st = 0;      // 0 idle, 1 xoff, 2 sleep
    int m_pend = 0;    // 0 none, else target state
    bit m_err = 1'b0;
    bit m_stable = 1'b0;

    function automatic bit m_osc();
        return force_on || (m_st == 0);
    endfunction

    always @(posedge clk) begin
        if (!por_n) begin
            m_st = 0; m_pend = 0; m_err = 0; m_stable = 0;
        end else begin
            bit pw;
            m_stable = m_osc() && xs;
            pw = strobe[1] || strobe[2];
            if (strobe[0]) begin
                m_st = 0; m_pend = 0; m_err = 0;
            end else if (m_st != 0) begin
                if (pw) m_err = 1;
                if (!cs_n) m_st = 0;
            end else if (m_pend != 0) begin
                if (pw) m_err = 1;
                if (cs_n) begin m_st = m_pend; m_pend = 0; end
            end else if (strobe[1]) m_pend = 1;
            else if (strobe[2]) m_pend = 2;
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (por_n) begin
            check("R3 R4 R5 R11 state", int'(state), m_st);
            check("R6 osc_en", int'(osc_en), int'(m_osc()));
            check("R7 reg_en", int'(reg_en), int'(m_st != 2));
            check("R2 R10 so_level", int'(so_level), int'(!m_stable));
            check("R8 so_oe", int'(so_oe), int'(!cs_n));
            check("R9 strobe_err", int'(serr), int'(m_err));
        end
    end

    task automatic step(int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic pulse(logic [2:0] s);
        strobe = s; step(1); strobe = 3'b000;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        // R1 during reset
        check("R1 reset state", int'(state), 0);
        check("R1 reset osc_en", int'(osc_en), 1);
        check("R1 reset reg_en", int'(reg_en), 1);
        check("R1 reset err", int'(serr), 0);
        check("R1 reset so_level", int'(so_level), 1);
        por_n = 1'b1;
        step(2);
        // R2 readiness while chip select low
        cs_n = 1'b0; step(3);
        xs = 1'b1; step(3);
        check("R2 ready low", int'(so_level), 0);
        // R3 oscillator-off held until release
        pulse(3'b010); step(3);
        check("R3 pending holds idle", int'(state), 0);
        cs_n = 1'b1; step(2);
        check("R3 xoff entered", int'(state), 1);
        // R9 strobe in xoff ignored and flagged
        pulse(3'b100); step(2);
        check("R9 ignored state", int'(state), 1);
        check("R9 flag set", int'(serr), 1);
        // R4 / R10 wake, stable held high throughout
        cs_n = 1'b0; step(1);
        check("R4 woke", int'(state), 0);
        check("R10 not ready after wake", int'(so_level), 1);
        step(2);
        // R5 reset strobe clears flag
        pulse(3'b001); step(1);
        check("R5 err cleared", int'(serr), 0);
        // R7 / R6 power-down with forced oscillator
        force_on = 1'b1;
        pulse(3'b100); cs_n = 1'b1; step(3);
        check("R7 sleep reg off", int'(reg_en), 0);
        check("R6 forced osc on", int'(osc_en), 1);
        force_on = 1'b0; step(2);
        cs_n = 1'b0; step(3);
        // R9 strobe on top of a pending request
        pulse(3'b010); pulse(3'b100); step(1);
        cs_n = 1'b1; step(2);
        check("R9 pending kept xoff", int'(state), 1);
        cs_n = 1'b0; step(2);
        pulse(3'b001);
        // R11 priority: xoff over power-down, reset over all
        pulse(3'b110); cs_n = 1'b1; step(2);
        check("R11 xoff wins", int'(state), 1);
        cs_n = 1'b0; step(2);
        pulse(3'b111); cs_n = 1'b1; step(3);
        check("R11 reset wins", int'(state), 0);
        // strobe with chip select already high, sleep without force
        pulse(3'b100); step(2);
        xs = 1'b0; step(3);
        cs_n = 1'b0; step(2); xs = 1'b1; step(3);
        cs_n = 1'b1; step(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule